// File: doc/BRIEF.md
# Speculative Reorder Buffer with Branch Tags

This block keeps instructions of an out-of-order core in program order while their results arrive in any order. Decode hands in one instruction per cycle over a valid/ready pair; the buffer gives it a slot and a path tag. The slot number also names the entry's rename register, which holds the result until commit. Execution units report completion, result data and a fault flag against a slot. From the oldest end, the buffer commits finished instructions in program order, up to a fixed number per cycle. It presents their destination register and result on commit lanes, which feed the architectural register file.

The block keeps a fault flag latent in its entry and acts on it only when that entry becomes the oldest unfinished commit candidate. At that point the buffer reports the fault's slot and discards every entry, including the faulting one. Each accepted branch advances the path tag given to the instructions after it. A mispredict, named by the branch's slot, discards everything younger than the branch in one cycle. The tail then rolls back to the slot after the branch, and the tag restarts from the branch's tag plus one. Squashed slots, and their rename registers, become free for allocation again straight away.

Back-pressure rules: an instruction transfers on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low when all slots hold live entries. It is also low in any cycle that carries a mispredict or takes a fault. While `in_ready` is low, decode holds its instruction. Completion, mispredict, commit and fault pins are plain strobes with no handshake.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, no commit lane valid, `exc_valid`=0, and the first accepted instruction takes slot 0 with tag 0.
- R2: `in_ready` is high exactly when fewer than DEPTH entries are live, `mp_valid` is low and no fault is taken this cycle. Accepted instructions take consecutive slots that wrap from DEPTH-1 to 0. `full` is high when DEPTH entries are live and `empty` when none are.
- R3: `alloc_tag` shows the path tag of the instruction being accepted. After an accepted instruction with `in_branch`=1, the tag of later instructions is one higher, modulo 2^TAG_W.
- R4: `wb_valid` marks the live entry in `wb_slot` complete, storing `wb_data` and the fault flag `wb_fault`. A completion aimed at a slot that holds no live entry has no effect, even if that slot is allocated later.
- R5: Commit takes entries in program order, oldest first, up to RET_W per cycle, and stops at the first entry that is not complete. Valid lanes are contiguous from lane 0, and lane k carries that entry's destination register and result.
- R6: When the oldest entry that is not committed in a cycle is complete and carries a fault, `exc_valid` pulses with `exc_slot` set to its slot. Only the older entries in front of it commit that cycle. All entries, including the faulting one, are discarded, and the buffer is empty in the next cycle.
- R7: With `mp_valid` high, every entry younger than the branch in `mp_slot` is discarded that cycle, and no such entry commits. The next accepted instruction takes the slot after the branch, with the branch's tag plus one.
- R8: A fault taken in the same cycle as a mispredict wins: the whole buffer is discarded.
- R9: A completion presented in cycle t makes its entry eligible to commit in cycle t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode offers an instruction |
| in_ready | output | 1 | Buffer accepts the offered instruction |
| in_dest | input | AREG_W | Architectural destination register |
| in_branch | input | 1 | Offered instruction is a predicted branch |
| alloc_slot | output | IDX_W | Slot (and rename register) given to the accepted instruction |
| alloc_tag | output | TAG_W | Path tag given to the accepted instruction |
| wb_valid | input | 1 | Completion strobe |
| wb_slot | input | IDX_W | Slot being completed |
| wb_data | input | DATA_W | Result value |
| wb_fault | input | 1 | Execution raised a fault |
| mp_valid | input | 1 | Branch resolved as mispredicted |
| mp_slot | input | IDX_W | Slot of the mispredicted branch |
| ret_valid | output | RET_W | Commit lane valid, lane 0 oldest |
| ret_dest | output | RET_W*AREG_W | Destination register per lane |
| ret_data | output | RET_W*DATA_W | Result per lane |
| exc_valid | output | 1 | Fault taken at commit |
| exc_slot | output | IDX_W | Slot of the faulting entry |
| full | output | 1 | All slots live |
| empty | output | 1 | No slot live |

## Verification
The bench builds the buffer with DEPTH=8, RET_W=4, TAG_W=3, AREG_W=5 and DATA_W=16. Eight slots put the full condition and pointer wrap within a few cycles of traffic. Four commit lanes against eight slots let a single cycle drain half the buffer, and a fault can land on any lane. A three-bit tag wraps after eight branches, so tag rollover and rollback after a mispredict are both exercised many times in one run.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Why the buffer discards entries in a cycle
  typedef enum logic [1:0] {
    FL_NONE    = 2'd0,
    FL_MISPRED = 2'd1,
    FL_FAULT   = 2'd2
  } flush_e;

  // Modular add on a ring of 'depth' positions; a < depth, b <= depth
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned depth);
    int unsigned s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/rob_store.sv
module rob_store #(
  parameter int DEPTH  = 60,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic [AREG_W-1:0] alloc_dest,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              wb_fault,
  input  logic [DEPTH-1:0]  kill,
  output logic              done  [DEPTH],
  output logic              fault [DEPTH],
  output logic [AREG_W-1:0] dest  [DEPTH],
  output logic [TAG_W-1:0]  tag   [DEPTH],
  output logic [DATA_W-1:0] data  [DEPTH]
);

  logic live [DEPTH];

  // Control bits: kill beats allocation beats completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < DEPTH; s++) begin
        live[s]  <= 1'b0;
        done[s]  <= 1'b0;
        fault[s] <= 1'b0;
      end
    end else begin
      for (int s = 0; s < DEPTH; s++) begin
        if (kill[s]) begin
          live[s] <= 1'b0;
        end else if (alloc_en && alloc_idx == IDX_W'(s)) begin
          live[s]  <= 1'b1;
          done[s]  <= 1'b0;
          fault[s] <= 1'b0;
        end else if (wb_en && live[s] && wb_idx == IDX_W'(s)) begin
          done[s]  <= 1'b1;
          fault[s] <= wb_fault;
        end
      end
    end
  end

  // Payload: slot-indexed rename registers, no reset needed
  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (alloc_en && alloc_idx == IDX_W'(s)) begin
        dest[s] <= alloc_dest;
        tag[s]  <= alloc_tag;
      end
      if (wb_en && live[s] && wb_idx == IDX_W'(s)) begin
        data[s] <= wb_data;
      end
    end
  end

endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel #(
  parameter int DEPTH = 60,
  parameter int RET_W = 4,
  parameter int IDX_W = 6,
  parameter int CNT_W = 6
) (
  input  logic [IDX_W-1:0] head,
  input  logic [CNT_W-1:0] count,
  input  logic             done  [DEPTH],
  input  logic             fault [DEPTH],
  input  logic             lim_en,
  input  logic [CNT_W-1:0] lim,
  output logic [RET_W-1:0] ret_mask,
  output logic [CNT_W-1:0] nret,
  output logic             fault_take,
  output logic [CNT_W-1:0] fault_pos
);

  always_comb begin
    logic        go;
    int unsigned slot;
    go         = 1'b1;
    ret_mask   = '0;
    nret       = '0;
    fault_take = 1'b0;
    fault_pos  = '0;
    for (int k = 0; k < RET_W; k++) begin
      slot = rob_pkg::ring_add(32'(head), k, DEPTH);
      if (go && CNT_W'(k) < count && done[slot] && !(lim_en && CNT_W'(k) > lim)) begin
        if (fault[slot]) begin
          fault_take = 1'b1;
          fault_pos  = CNT_W'(k);
          go         = 1'b0;
        end else begin
          ret_mask[k] = 1'b1;
          nret        = nret + CNT_W'(1);
        end
      end else begin
        go = 1'b0;
      end
    end
  end

endmodule

// File: rtl/spec_rob.sv
module spec_rob #(
  parameter int DEPTH  = 60,
  parameter int RET_W  = 4,
  parameter int AREG_W = 5,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [AREG_W-1:0]       in_dest,
  input  logic                    in_branch,
  output logic [IDX_W-1:0]        alloc_slot,
  output logic [TAG_W-1:0]        alloc_tag,
  input  logic                    wb_valid,
  input  logic [IDX_W-1:0]        wb_slot,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_fault,
  input  logic                    mp_valid,
  input  logic [IDX_W-1:0]        mp_slot,
  output logic [RET_W-1:0]        ret_valid,
  output logic [RET_W*AREG_W-1:0] ret_dest,
  output logic [RET_W*DATA_W-1:0] ret_data,
  output logic                    exc_valid,
  output logic [IDX_W-1:0]        exc_slot,
  output logic                    full,
  output logic                    empty
);

  import rob_pkg::*;

  logic [IDX_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [TAG_W-1:0]  tag_ctr;
  logic              e_done  [DEPTH];
  logic              e_fault [DEPTH];
  logic [AREG_W-1:0] e_dest  [DEPTH];
  logic [TAG_W-1:0]  e_tag   [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];
  logic [DEPTH-1:0]  kill;
  logic [CNT_W-1:0]  nret, fault_pos, mp_dist;
  logic              fault_take, accept;
  flush_e            cause;

  // Age of the mispredicted branch counted from the head
  assign mp_dist = CNT_W'(ring_add(32'(mp_slot), DEPTH - 32'(head), DEPTH));

  rob_retire_sel #(.DEPTH(DEPTH), .RET_W(RET_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sel (
    .head(head), .count(count), .done(e_done), .fault(e_fault),
    .lim_en(mp_valid), .lim(mp_dist),
    .ret_mask(ret_valid), .nret(nret), .fault_take(fault_take), .fault_pos(fault_pos)
  );

  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign in_ready  = !full && !mp_valid && !fault_take;
  assign accept    = in_valid && in_ready;
  assign alloc_slot = tail;
  assign alloc_tag  = tag_ctr;
  assign exc_valid  = fault_take;
  assign exc_slot   = IDX_W'(ring_add(32'(head), 32'(fault_pos), DEPTH));
  assign cause = fault_take ? FL_FAULT : (mp_valid ? FL_MISPRED : FL_NONE);

  // Per-slot discard: committed this cycle, fault flush, or younger than branch
  always_comb begin
    int unsigned age;
    for (int s = 0; s < DEPTH; s++) begin
      age = ring_add(s, DEPTH - 32'(head), DEPTH);
      kill[s] = fault_take || (age < 32'(nret)) || (mp_valid && age > 32'(mp_dist));
    end
  end

  rob_store #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(accept), .alloc_idx(tail), .alloc_dest(in_dest), .alloc_tag(tag_ctr),
    .wb_en(wb_valid), .wb_idx(wb_slot), .wb_data(wb_data), .wb_fault(wb_fault),
    .kill(kill),
    .done(e_done), .fault(e_fault), .dest(e_dest), .tag(e_tag), .data(e_data)
  );

  // Commit lanes read the entries in front of the head
  for (genvar k = 0; k < RET_W; k++) begin : g_lane
    localparam int unsigned KK = k;
    logic [IDX_W-1:0] lane_slot;
    assign lane_slot = IDX_W'(ring_add(32'(head), KK, DEPTH));
    assign ret_dest[k*AREG_W +: AREG_W] = e_dest[lane_slot];
    assign ret_data[k*DATA_W +: DATA_W] = e_data[lane_slot];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      tag_ctr <= '0;
    end else begin
      unique case (cause)
        FL_FAULT: begin
          head  <= tail;
          count <= '0;
        end
        FL_MISPRED: begin
          head    <= IDX_W'(ring_add(32'(head), 32'(nret), DEPTH));
          tail    <= IDX_W'(ring_add(32'(mp_slot), 1, DEPTH));
          count   <= mp_dist + CNT_W'(1) - nret;
          tag_ctr <= e_tag[mp_slot] + TAG_W'(1);
        end
        default: begin
          head  <= IDX_W'(ring_add(32'(head), 32'(nret), DEPTH));
          count <= count - nret + CNT_W'(accept);
          if (accept) begin
            tail <= IDX_W'(ring_add(32'(tail), 1, DEPTH));
            if (in_branch) tag_ctr <= tag_ctr + TAG_W'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/rob_sva.sv
module rob_sva #(
  parameter int RET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             mp_valid,
  input logic [RET_W-1:0] ret_valid,
  input logic             exc_valid,
  input logic             empty
);

  // R1: nothing commits or faults out of an empty buffer
  a_r1_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (ret_valid == '0 && !exc_valid));

  // R2: an accepted instruction leaves the buffer non-empty
  a_r2_alloc_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !empty);

  // R5: commit lanes fill from lane 0 without gaps
  a_r5_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid & (ret_valid + RET_W'(1))) == '0);

  // R6: a taken fault leaves the buffer empty next cycle
  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> empty);

  // R6: the faulting entry occupies a lane, so the last lane cannot commit
  a_r6_lane_left: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> !ret_valid[RET_W-1]);

  // R7: the mispredicted branch itself survives when nothing commits
  a_r7_branch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_valid && !exc_valid && !ret_valid[0]) |=> !empty);

endmodule

bind spec_rob rob_sva #(.RET_W(RET_W)) u_rob_sva (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .mp_valid(mp_valid), .ret_valid(ret_valid), .exc_valid(exc_valid), .empty(empty)
);

// File: tb/test_spec_rob.sv
`timescale 1ns/1ps
module test_spec_rob;

  localparam int D  = 8;
  localparam int RW = 4;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int TW = 3;
  localparam int IW = $clog2(D);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          in_valid = 1'b0, in_branch = 1'b0;
  logic [AW-1:0] in_dest = '0;
  logic          in_ready;
  logic [IW-1:0] alloc_slot;
  logic [TW-1:0] alloc_tag;
  logic          wb_valid = 1'b0, wb_fault = 1'b0;
  logic [IW-1:0] wb_slot = '0;
  logic [DW-1:0] wb_data = '0;
  logic          mp_valid = 1'b0;
  logic [IW-1:0] mp_slot = '0;
  logic [RW-1:0] ret_valid;
  logic [RW*AW-1:0] ret_dest;
  logic [RW*DW-1:0] ret_data;
  logic          exc_valid, full, empty;
  logic [IW-1:0] exc_slot;

  spec_rob #(.DEPTH(D), .RET_W(RW), .AREG_W(AW), .DATA_W(DW), .TAG_W(TW)) i_spec_rob (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dest(in_dest), .in_branch(in_branch), .alloc_slot(alloc_slot), .alloc_tag(alloc_tag),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_data(wb_data), .wb_fault(wb_fault),
    .mp_valid(mp_valid), .mp_slot(mp_slot), .ret_valid(ret_valid), .ret_dest(ret_dest),
    .ret_data(ret_data), .exc_valid(exc_valid), .exc_slot(exc_slot), .full(full), .empty(empty)
  );

  typedef struct {
    int slot; int dest; int tag; bit br; bit done; bit flt; int data;
  } ent_t;

  ent_t q[$];
  int   mtail = 0, mtag = 0;
  int   n_cmp = 0, n_bad = 0;
  bit   prev_mp = 0;
  int   prev_mp_next = 0, prev_mp_tag = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "empty", int'(empty), 1);
    chk("R1", "full", int'(full), 0);
    chk("R1", "ret_valid", int'(ret_valid), 0);
    chk("R1", "exc_valid", int'(exc_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "first slot", int'(alloc_slot), 0);
    chk("R1", "first tag", int'(alloc_tag), 0);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      int wb_rate, flt_rate, mp_rate, pb, nr, et, ep, idx;
      bit exp_ready;
      int cand[$];
      @(negedge clk);
      wb_rate  = (cyc < 300) ? 8 : ((cyc < 3000) ? 2 : 1);
      flt_rate = (cyc < 3000) ? 40 : 8;
      mp_rate  = (cyc < 1500) ? 30 : 8;

      in_valid  = ($urandom % 4) != 0;
      in_dest   = AW'($urandom);
      in_branch = ($urandom % 3) == 0;

      // completion: live incomplete entry, or sometimes a free slot (R4)
      cand.delete();
      foreach (q[i]) if (!q[i].done) cand.push_back(q[i].slot);
      wb_valid = 1'b0;
      if (cand.size() > 0 && ($urandom % wb_rate) == 0) begin
        wb_valid = 1'b1;
        wb_slot  = IW'(cand[$urandom % cand.size()]);
      end else if (q.size() < D && ($urandom % 6) == 0) begin
        wb_valid = 1'b1;
        wb_slot  = IW'(mtail);
      end
      wb_data  = DW'($urandom);
      wb_fault = ($urandom % flt_rate) == 0;

      cand.delete();
      foreach (q[i]) if (q[i].br) cand.push_back(i);
      mp_valid = 1'b0;
      pb = -1;
      if (cand.size() > 0 && ($urandom % mp_rate) == 0) begin
        pb = cand[$urandom % cand.size()];
        mp_valid = 1'b1;
        mp_slot  = IW'(q[pb].slot);
      end
      #1;

      // expected commit from the state before this edge
      nr = 0; et = 0; ep = 0;
      for (int k = 0; k < RW && k < q.size(); k++) begin
        if (!q[k].done) break;
        if (mp_valid && k > pb) break;
        if (q[k].flt) begin et = 1; ep = q[k].slot; break; end
        nr++;
      end
      exp_ready = (q.size() < D) && !mp_valid && (et == 0);

      chk("R2", "in_ready", int'(in_ready), int'(exp_ready));
      chk("R2", "full", int'(full), int'(q.size() == D));
      chk("R2", "empty", int'(empty), int'(q.size() == 0));
      chk("R9", "commit count", $countones(ret_valid), nr);
      for (int k = 0; k < RW; k++) begin
        chk("R5", $sformatf("lane %0d valid", k), int'(ret_valid[k]), int'(k < nr));
        if (k < nr) begin
          chk("R5", $sformatf("lane %0d dest", k), int'(ret_dest[k*AW +: AW]), q[k].dest);
          chk("R4", $sformatf("lane %0d data", k), int'(ret_data[k*DW +: DW]), q[k].data);
        end
      end
      chk(mp_valid ? "R8" : "R6", "exc_valid", int'(exc_valid), et);
      if (et != 0) chk("R6", "exc_slot", int'(exc_slot), ep);
      if (in_valid && exp_ready) begin
        chk(prev_mp ? "R7" : "R2", "alloc_slot", int'(alloc_slot), mtail);
        chk(prev_mp ? "R7" : "R3", "alloc_tag", int'(alloc_tag), mtag);
      end
      if (prev_mp && exp_ready) begin
        chk("R7", "rollback slot", int'(alloc_slot), prev_mp_next);
        chk("R7", "rollback tag", int'(alloc_tag), prev_mp_tag);
      end

      // reference update
      prev_mp = 0;
      if (wb_valid) foreach (q[i]) if (q[i].slot == int'(wb_slot) && !q[i].done) begin
        q[i].done = 1; q[i].flt = wb_fault; q[i].data = int'(wb_data);
      end
      if (et != 0) begin
        q.delete();
      end else begin
        if (mp_valid) begin
          idx = pb - nr;
          mtail = (q[pb].slot + 1) % D;
          mtag  = (q[pb].tag + 1) % (1 << TW);
          prev_mp = 1; prev_mp_next = mtail; prev_mp_tag = mtag;
        end
        for (int k = 0; k < nr; k++) void'(q.pop_front());
        if (mp_valid) while (q.size() > idx + 1) void'(q.pop_back());
      end
      if (in_valid && exp_ready) begin
        ent_t e;
        e.slot = mtail; e.dest = int'(in_dest); e.tag = mtag; e.br = in_branch;
        e.done = 0; e.flt = 0; e.data = 0;
        q.push_back(e);
        mtail = (mtail + 1) % D;
        if (in_branch) mtag = (mtag + 1) % (1 << TW);
      end
    end

    summary();
    $finish;
  end

endmodule